// File: doc/BRIEF.md
# Selectable-Accuracy 4x4 Compressor Multiplier

This block multiplies two 4-bit unsigned operands in a single combinational path. The sixteen AND partial products are sorted into columns by weight. A shallow Dadda-style tree of one half adder, two 4:2 compressors and one full adder brings them down to two rows. An 8-bit carry-propagate add then gives the product.

A build-time parameter picks the logic inside both 4:2 compressors. The exact cell gives a true product. The first cheap cell drops the carry-in/carry-out path: its carry simply forwards the incoming carry, and its sum and carry-out use reduced gates. The second cheap cell has neither carry-in nor carry-out, and builds its two outputs from OR-ed pair terms. The approximate builds are meant for error-tolerant datapaths such as image filters. There, a smaller and faster partial-product stage is worth an occasional wrong low-order result.

Top module: `approx_mul4x4`

## Requirements
- R1: With `CELL_MODE` = 0 (exact cell), `prod` equals `x * y` for every one of the 256 operand pairs.
- R2: In every mode, a zero on either operand gives `prod` = 0.
- R3: In every mode, if either operand is a power of two (1, 2, 4 or 8), `prod` equals the true product.
- R4: With `CELL_MODE` = 1 (first approximate cell), 15 × 15 gives 225.
- R5: With `CELL_MODE` = 2 (second approximate cell), 15 × 15 gives 177.
- R6: Each approximate mode (1 and 2) differs from the true product for at least one operand pair. Mode 2 matches the true product for more pairs than mode 1.
- R7: The exact compressor conserves weight: its sum plus twice its carry plus twice its carry-out equals the count of ones on its five inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 4 | Multiplicand, unsigned |
| y | input | 4 | Multiplier, unsigned |
| prod | output | 8 | Product, exact or approximate by `CELL_MODE` |

## Verification
The two compressors sit in adjacent columns. The one at weight 8 feeds its carry, and in the exact and first modes also its carry-out, into the one at weight 16. Both cells therefore approximate within the same evaluation whenever both columns are densely populated. The all-ones operand pair fills every input of both cells at once. It is applied to each mode, and the result is judged against the fixed values in R4 and R5. A full sweep then counts how often each mode matches the true product, and compares those counts.

// File: rtl/approx_mul4x4.sv
module approx_mul4x4 #(
  parameter int CELL_MODE = 0
) (
  input  logic [3:0] x,
  input  logic [3:0] y,
  output logic [7:0] prod
);
  localparam int N = 4;
  localparam bit HAS_CIN = (CELL_MODE != 2);

  logic [N*N-1:0] pp;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      assign pp[N*i+j] = x[i] & y[j];
    end
  end

  // returns {cout, carry, sum}
  function automatic logic [2:0] cell42(input logic i0, i1, i2, i3, ci);
    logic t, u;
    logic [2:0] r;
    case (CELL_MODE)
      1: begin
        r[0] = ((i0 ^ i1) | (i2 ^ i3)) ^ ci;
        r[1] = ci;
        r[2] = (i0 & i1) | (i2 & i3);
      end
      2: begin
        r[0] = (i0 ^ i1) | (i2 ^ i3);
        r[1] = (i0 & i1) | (i2 & i3);
        r[2] = 1'b0;
      end
      default: begin
        t    = i0 ^ i1 ^ i2;
        u    = t ^ i3;
        r[0] = u ^ ci;
        r[1] = (u & ci) | (~u & i3);
        r[2] = ((i0 ^ i1) & i2) | (i0 & i1);
      end
    endcase
    return r;
  endfunction

  logic       h_s, h_c;
  logic [2:0] c3, c4;
  logic       f_s, f_c;
  logic [7:0] row_a, row_b;

  assign h_s = pp[N*0+2] ^ pp[N*1+1];
  assign h_c = pp[N*0+2] & pp[N*1+1];

  assign c3 = cell42(pp[N*0+3], pp[N*1+2], pp[N*2+1], pp[N*3+0],
                     HAS_CIN ? h_c : 1'b0);
  assign c4 = cell42(pp[N*1+3], pp[N*2+2], pp[N*3+1], c3[1],
                     HAS_CIN ? c3[2] : 1'b0);

  assign f_s = pp[N*2+3] ^ pp[N*3+2] ^ c4[1];
  assign f_c = (pp[N*2+3] & pp[N*3+2]) | (c4[1] & (pp[N*2+3] ^ pp[N*3+2]));

  assign row_a = {1'b0, pp[N*3+3], f_s, c4[0], c3[0], h_s, pp[N*0+1], pp[N*0+0]};
  assign row_b = {1'b0, f_c, c4[2], 1'b0, HAS_CIN ? 1'b0 : h_c,
                  pp[N*2+0], pp[N*1+0], 1'b0};

  assign prod = row_a + row_b;

  always_comb begin
    if (x == 4'd0 || y == 4'd0)
      assert_zero_operand_R2: assert (prod == 8'd0);
    if ($countones(x) == 1 || $countones(y) == 1)
      assert_pow2_exact_R3: assert (prod == 8'(x * y));
    if (CELL_MODE == 0) begin
      assert_exact_product_R1: assert (prod == 8'(x * y));
      assert_cell_weight_R7: assert (
        32'(c3[0]) + 2 * (32'(c3[1]) + 32'(c3[2])) ==
        32'(pp[N*0+3]) + 32'(pp[N*1+2]) + 32'(pp[N*2+1]) + 32'(pp[N*3+0]) + 32'(h_c));
    end
  end
endmodule

// File: tb/approx_mul4x4_tb.sv
module approx_mul4x4_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] x, y;
  logic [7:0] p0, p1, p2;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit ended = 1'b0;

  approx_mul4x4 #(.CELL_MODE(0)) u_dut    (.x(x), .y(y), .prod(p0));
  approx_mul4x4 #(.CELL_MODE(1)) u_dut_c1 (.x(x), .y(y), .prod(p1));
  approx_mul4x4 #(.CELL_MODE(2)) u_dut_c2 (.x(x), .y(y), .prod(p2));

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s x=%0d y=%0d actual=%0d expected=%0d", req, x, y, got, exp);
    end
  endtask

  task automatic apply(input int a, input int b);
    @(negedge clk);
    x = 4'(a);
    y = 4'(b);
    #2;
  endtask

  task automatic t_start;
    apply(0, 0);
    check("R2 mode0", p0, 0);
    check("R2 mode1", p1, 0);
    check("R2 mode2", p2, 0);
  endtask

  task automatic t_exact_sweep;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        apply(a, b);
        check("R1", p0, a * b);
      end
  endtask

  task automatic t_zero;
    for (int v = 0; v < 16; v++) begin
      apply(v, 0);
      check("R2 mode1 y=0", p1, 0);
      check("R2 mode2 y=0", p2, 0);
      apply(0, v);
      check("R2 mode1 x=0", p1, 0);
      check("R2 mode2 x=0", p2, 0);
    end
  endtask

  task automatic t_pow2;
    for (int k = 0; k < 4; k++)
      for (int v = 0; v < 16; v++) begin
        apply(v, 1 << k);
        check("R3 mode1 y pow2", p1, v * (1 << k));
        check("R3 mode2 y pow2", p2, v * (1 << k));
        apply(1 << k, v);
        check("R3 mode1 x pow2", p1, v * (1 << k));
        check("R3 mode2 x pow2", p2, v * (1 << k));
      end
  endtask

  task automatic t_all_ones;
    apply(15, 15);
    check("R4", p1, 225);
    check("R5", p2, 177);
    check("R1 all ones", p0, 225);
  endtask

  task automatic t_match_counts;
    int m1 = 0;
    int m2 = 0;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        apply(a, b);
        if (p1 == 8'(a * b)) m1++;
        if (p2 == 8'(a * b)) m2++;
      end
    $display("matches of 256: mode1=%0d mode2=%0d", m1, m2);
    check("R6 mode1 approximate", int'(m1 < 256), 1);
    check("R6 mode2 approximate", int'(m2 < 256), 1);
    check("R6 mode2 beats mode1", int'(m2 > m1), 1);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !ended) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    x = 4'd0;
    y = 4'd0;
    t_start();
    t_exact_sweep();
    t_zero();
    t_pow2();
    t_all_ones();
    t_match_counts();
    finish_run();
  end
endmodule